// File: doc/BRIEF.md
# Card Power Activation Sequencer

This block is the session controller for one contact card slot. It runs from a slow internal oscillator and measures all sequencing in a time unit T, fixed at twice a programmable half-unit of oscillator cycles (64 cycles per T by default). When the host pulls its active-low start request low, the block brings the slot up in steps:
- the step-up converter enable,
- the card supply enable,
- the I/O enable and the card clock gate,
- the card reset path.

When the request is released, or when a fault appears, the block takes the slot down in the reverse order and ends with every contact tied low.

The block has one active-low status line. Outside a session it reports whether a card sits in the slot. Within a session it drops when the card is pulled out, when the supply overcurrent flag rises or when the overtemperature flag rises. That low level is held until the host lifts its start request. A supply-voltage alarm also ends the session, but it leaves the status line untouched. After the alarm clears, it holds the sequencer idle for a stretched interval. The reset request input has two roles. Before reset release it can hold back the card clock, so that the host can count clock pulses before reset rises. After reset release it drives the card reset pin.

Top module: `scs_ctrl`

## Requirements
- R1: Taking the acceptance edge as cycle 0 and H as the half-unit, the converter enable is high from cycle 0, the supply enable from cycle 3H, and the I/O enable from cycle 8H.
- R2: If the reset request is low when the start is accepted, the clock gate opens together with the I/O enable at cycle 8H.
- R3: If the reset request is high when the start is accepted, the clock gate stays closed until the reset request is low at or after cycle 8H. Once open, it stays open whatever the reset request does. It is forced open from cycle 14H.
- R4: The card reset output is low before cycle 14H. From cycle 14H on, it follows the reset request.
- R5: The start request going high causes an ordered shutdown, with the entry edge taken as cycle 0. Card reset is low from cycle 0. The clock closes at H, the I/O enable drops at 2H, the supply at 3H and the converter at 10H. At 10H the block is idle.
- R6: While the start request is high, the status line is high exactly when a card is present. A card is present when pres_n is 0 or pres is 1.
- R7: During a session, card absence, overcurrent or overtemperature starts shutdown at the next edge and drives the status line low at the same edge. The status line stays low, even if the cause clears, until the start request goes high.
- R8: A supply alarm during a session starts shutdown at the next edge. The status line stays high.
- R9: A start is refused while the supply alarm is high and for STRETCH_CYC cycles after it falls. The same hold applies for STRETCH_CYC cycles after reset.
- R10: A start is accepted only from idle, and only after the start request has been high since the previous acceptance. A request that falls during shutdown is accepted at the edge after the block reaches idle.
- R11: An enable that had not yet turned on when shutdown began stays off throughout shutdown.
- R12: A start request with no card present is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low session request |
| rst_req | input | 1 | Card reset request from the host |
| pres_n | input | 1 | Active-low card presence contact |
| pres | input | 1 | Active-high card presence contact |
| ovc | input | 1 | Card supply overcurrent flag |
| ovt | input | 1 | Overtemperature flag |
| supply_alarm | input | 1 | Host supply low alarm |
| pump_en | output | 1 | Step-up converter enable |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O lines enable |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset output |
| stat_n | output | 1 | Active-low status / interrupt |

## Verification
A start, stop or fault request takes effect at the next clock edge. The step enables then change exactly at whole multiples of H cycles after that edge. The exceptions are card_rst and clk_en, which follow the reset request within the same cycle once their window is open. With the half-unit shortened to 4 cycles, the bench counts cycles from each entry edge. It compares all six outputs against arithmetic step boundaries at every cycle of every up and down phase, sampling 2 ns after each edge. The alarm-stretch hold is checked on the exact cycle before acceptance and on the cycle after.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_ON   = 2'd2,
        PH_DOWN = 2'd3
    } phase_e;

    typedef struct packed {
        logic pump;
        logic vcc;
        logic io;
        logic clk;
    } rails_t;

    localparam int STEP_W = 4;
    localparam logic [STEP_W-1:0] STEP_MAX = '1;

    // half-unit indices of the power-up grid
    localparam logic [STEP_W-1:0] UP_VCC = 4'd3;
    localparam logic [STEP_W-1:0] UP_IO  = 4'd8;
    localparam logic [STEP_W-1:0] UP_RST = 4'd14;

    // half-unit indices of the shutdown grid
    localparam logic [STEP_W-1:0] DN_CLK = 4'd1;
    localparam logic [STEP_W-1:0] DN_IO  = 4'd2;
    localparam logic [STEP_W-1:0] DN_VCC = 4'd3;
    localparam logic [STEP_W-1:0] DN_END = 4'd10;

    localparam rails_t RAILS_OFF = '{pump: 1'b0, vcc: 1'b0, io: 1'b0, clk: 1'b0};
    localparam rails_t RAILS_ALL = '{pump: 1'b1, vcc: 1'b1, io: 1'b1, clk: 1'b1};

    function automatic rails_t rails_rising(input logic [STEP_W-1:0] step, input logic clk_ok);
        rails_t r;
        r.pump = 1'b1;
        r.vcc  = (step >= UP_VCC);
        r.io   = (step >= UP_IO);
        r.clk  = (step >= UP_IO) && clk_ok;
        return r;
    endfunction

    function automatic rails_t rails_falling(input rails_t held, input logic [STEP_W-1:0] step);
        rails_t r;
        r.pump = held.pump & (step < DN_END);
        r.vcc  = held.vcc  & (step < DN_VCC);
        r.io   = held.io   & (step < DN_IO);
        r.clk  = held.clk  & (step < DN_CLK);
        return r;
    endfunction

endpackage

// File: rtl/scs_tick.sv
module scs_tick
    import scs_pkg::*;
#(
    parameter int HALF_T = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    output logic [STEP_W-1:0] step,
    output logic              step_end
);

    localparam int SUB_W = (HALF_T > 1) ? $clog2(HALF_T) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF_T - 1);

    logic [SUB_W-1:0] sub;

    assign step_end = (sub == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sub  <= '0;
            step <= '0;
        end else if (step_end) begin
            sub <= '0;
            if (step != STEP_MAX) begin
                step <= step + 1'b1;
            end
        end else begin
            sub <= sub + 1'b1;
        end
    end

endmodule

// File: rtl/scs_guard.sv
module scs_guard
    import scs_pkg::*;
#(
    parameter int STRETCH_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    input  logic in_session,
    input  logic pres_n,
    input  logic pres,
    input  logic ovc,
    input  logic ovt,
    input  logic supply_alarm,
    output logic present,
    output logic blocked,
    output logic fault_q,
    output logic trip
);

    localparam int CNT_W = $clog2(STRETCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYC);

    logic [CNT_W-1:0] hold_cnt;
    logic             fault_now;

    assign present   = !pres_n || pres;
    assign fault_now = ovc || ovt || !present;
    assign blocked   = supply_alarm || (hold_cnt != '0);
    assign trip      = in_session && (fault_now || fault_q || supply_alarm);

    // supply alarm stretcher, also armed by reset
    always_ff @(posedge clk) begin
        if (rst || supply_alarm) begin
            hold_cnt <= CNT_LOAD;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // flagged fault memory, released only by the host lifting its request
    always_ff @(posedge clk) begin
        if (rst || start_n) begin
            fault_q <= 1'b0;
        end else if (in_session && fault_now) begin
            fault_q <= 1'b1;
        end
    end

endmodule

// File: rtl/scs_seq.sv
module scs_seq
    import scs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic              rst_req,
    input  logic              present,
    input  logic              blocked,
    input  logic              fault_q,
    input  logic              trip,
    input  logic [STEP_W-1:0] step,
    input  logic              step_end,
    output logic              restart,
    output logic              in_session,
    output rails_t            rails,
    output logic              card_rst
);

    phase_e phase_q, phase_d;
    rails_t held_q;
    logic   rearm_q;
    logic   clk_armed_q;
    logic   accept;

    assign accept     = (phase_q == PH_IDLE) && !start_n && rearm_q
                        && !blocked && present && !fault_q;
    assign in_session = (phase_q == PH_UP) || (phase_q == PH_ON);

    always_comb begin
        phase_d = phase_q;
        restart = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    phase_d = PH_UP;
                    restart = 1'b1;
                end
            end
            PH_UP: begin
                if (start_n || trip) begin
                    phase_d = PH_DOWN;
                    restart = 1'b1;
                end else if (step_end && (step == UP_RST - 1'b1)) begin
                    phase_d = PH_ON;
                end
            end
            PH_ON: begin
                if (start_n || trip) begin
                    phase_d = PH_DOWN;
                    restart = 1'b1;
                end
            end
            PH_DOWN: begin
                if (step_end && (step == DN_END - 1'b1)) begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_comb begin
        unique case (phase_q)
            PH_UP:   rails = rails_rising(step, clk_armed_q || !rst_req);
            PH_ON:   rails = RAILS_ALL;
            PH_DOWN: rails = rails_falling(held_q, step);
            default: rails = RAILS_OFF;
        endcase
    end

    assign card_rst = (phase_q == PH_ON) && rst_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            held_q      <= RAILS_OFF;
            rearm_q     <= 1'b0;
            clk_armed_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                rearm_q <= 1'b0;
            end else if (start_n) begin
                rearm_q <= 1'b1;
            end
            if (accept) begin
                clk_armed_q <= !rst_req;
            end else if ((phase_q == PH_UP) && (step >= UP_IO) && !rst_req) begin
                clk_armed_q <= 1'b1;
            end
            if (in_session && (phase_d == PH_DOWN)) begin
                held_q <= rails;
            end
        end
    end

endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
    import scs_pkg::*;
#(
    parameter int HALF_T      = 32,
    parameter int STRETCH_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    input  logic rst_req,
    input  logic pres_n,
    input  logic pres,
    input  logic ovc,
    input  logic ovt,
    input  logic supply_alarm,
    output logic pump_en,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic card_rst,
    output logic stat_n
);

    logic [STEP_W-1:0] step;
    logic              step_end;
    logic              restart;
    logic              in_session;
    logic              present;
    logic              blocked;
    logic              fault_q;
    logic              trip;
    rails_t            rails;

    scs_tick #(.HALF_T(HALF_T)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .step     (step),
        .step_end (step_end)
    );

    scs_guard #(.STRETCH_CYC(STRETCH_CYC)) u_guard (
        .clk          (clk),
        .rst          (rst),
        .start_n      (start_n),
        .in_session   (in_session),
        .pres_n       (pres_n),
        .pres         (pres),
        .ovc          (ovc),
        .ovt          (ovt),
        .supply_alarm (supply_alarm),
        .present      (present),
        .blocked      (blocked),
        .fault_q      (fault_q),
        .trip         (trip)
    );

    scs_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .rst_req    (rst_req),
        .present    (present),
        .blocked    (blocked),
        .fault_q    (fault_q),
        .trip       (trip),
        .step       (step),
        .step_end   (step_end),
        .restart    (restart),
        .in_session (in_session),
        .rails      (rails),
        .card_rst   (card_rst)
    );

    assign pump_en = rails.pump;
    assign vcc_en  = rails.vcc;
    assign io_en   = rails.io;
    assign clk_en  = rails.clk;
    assign stat_n  = start_n ? present : !fault_q;

endmodule

// File: rtl/scs_ctrl_chk.sv
module scs_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic start_n,
    input logic rst_req,
    input logic pres_n,
    input logic pres,
    input logic ovc,
    input logic ovt,
    input logic supply_alarm,
    input logic pump_en,
    input logic vcc_en,
    input logic io_en,
    input logic clk_en,
    input logic card_rst,
    input logic stat_n
);

    AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst) io_en |-> vcc_en); // R1
    AST_VCC_NEEDS_PUMP: assert property (@(posedge clk) disable iff (rst) vcc_en |-> pump_en); // R5
    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (rst) clk_en |-> io_en); // R2
    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst) card_rst |-> clk_en); // R4
    AST_FAULT_DROPS_RST: assert property (@(posedge clk) disable iff (rst) (!start_n && (ovc || ovt)) |=> !card_rst); // R7
    AST_STAT_OUTSIDE: assert property (@(posedge clk) disable iff (rst) start_n |-> (stat_n == (pres || !pres_n))); // R6
    AST_ALARM_DEACT: assert property (@(posedge clk) disable iff (rst) (supply_alarm && card_rst) |=> !card_rst); // R8
    AST_ALARM_BLOCKS: assert property (@(posedge clk) disable iff (rst) (supply_alarm && !pump_en) |=> !pump_en); // R9

endmodule

bind scs_ctrl scs_ctrl_chk u_chk (.*);

// File: tb/scs_ctrl_tb.sv
`timescale 1ns/1ps
module scs_ctrl_tb;

    localparam int H = 4;
    localparam int S = 20;

    logic clk = 1'b0;
    logic rst, start_n, rst_req, pres_n, pres, ovc, ovt, supply_alarm;
    logic pump_en, vcc_en, io_en, clk_en, card_rst, stat_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    scs_ctrl #(.HALF_T(H), .STRETCH_CYC(S)) u_dut (
        .clk(clk), .rst(rst), .start_n(start_n), .rst_req(rst_req),
        .pres_n(pres_n), .pres(pres), .ovc(ovc), .ovt(ovt),
        .supply_alarm(supply_alarm), .pump_en(pump_en), .vcc_en(vcc_en),
        .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .stat_n(stat_n)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_all(input string tag, input logic p, input logic v, input logic i,
                           input logic c, input logic r, input logic s);
        chk(tag, "pump_en", pump_en, p);
        chk(tag, "vcc_en", vcc_en, v);
        chk(tag, "io_en", io_en, i);
        chk(tag, "clk_en", clk_en, c);
        chk(tag, "card_rst", card_rst, r);
        chk(tag, "stat_n", stat_n, s);
    endtask

    // power-up phase, c counted from the acceptance edge
    task automatic run_up(input int first_c, input int last_c, input bit rq0,
                          input int drop_at, input int raise_at);
        for (int c = first_c; c <= last_c; c++) begin
            logic exp_clk;
            tick();
            if (rq0) exp_clk = (c >= 14*H) || ((c >= 8*H) && (drop_at >= 0) && (c >= drop_at));
            else     exp_clk = (c >= 8*H);
            chk("R1", "pump_en", pump_en, 1'b1);
            chk("R1", "vcc_en", vcc_en, c >= 3*H);
            chk("R1", "io_en", io_en, c >= 8*H);
            chk(rq0 ? "R3" : "R2", "clk_en", clk_en, exp_clk);
            chk("R4", "card_rst", card_rst, (c >= 14*H) && rst_req);
            chk("R7", "stat_n", stat_n, 1'b1);
            if (c == drop_at - 1)  rst_req = 1'b0;
            if (c == raise_at - 1) rst_req = 1'b1;
        end
    endtask

    // shutdown phase, d counted from the entry edge
    task automatic run_down(input string tag, input bit mv, input bit mi, input bit mc,
                            input logic s_exp, input int restart_at);
        for (int d = 0; d <= 10*H; d++) begin
            tick();
            chk(tag, "pump_en", pump_en, d < 10*H);
            chk((mv ? tag : "R11"), "vcc_en", vcc_en, mv && (d < 3*H));
            chk((mi ? tag : "R11"), "io_en", io_en, mi && (d < 2*H));
            chk((mc ? tag : "R11"), "clk_en", clk_en, mc && (d < H));
            chk(tag, "card_rst", card_rst, 1'b0);
            chk(tag, "stat_n", stat_n, s_exp);
            if (d == restart_at) start_n = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_n = 1'b1; rst_req = 1'b0; pres_n = 1'b0; pres = 1'b0;
        ovc = 1'b0; ovt = 1'b0; supply_alarm = 1'b0;
        repeat (3) tick();
        chk_all("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        tick();

        // R6: presence decode sweep, status outside a session
        for (int k = 0; k < 4; k++) begin
            pres_n = k[0];
            pres   = k[1];
            #1;
            chk("R6", "stat_n", stat_n, !k[0] || k[1]);
        end
        pres_n = 1'b0; pres = 1'b0;

        // R9: hold after reset
        start_n = 1'b0;
        repeat (5) begin
            tick();
            chk("R9", "pump_en", pump_en, 1'b0);
        end
        start_n = 1'b1;
        repeat (S + 5) tick();

        // R12: no card, no session
        pres_n = 1'b1;
        start_n = 1'b0;
        repeat (6) begin
            tick();
            chk("R12", "pump_en", pump_en, 1'b0);
        end
        start_n = 1'b1; pres_n = 1'b0;
        tick();

        // A: reset request low at start, normal stop
        start_n = 1'b0;
        run_up(0, 14*H + 4, 1'b0, -1, -1);
        rst_req = 1'b1; tick(); chk("R4", "card_rst", card_rst, 1'b1);
        rst_req = 1'b0; tick(); chk("R4", "card_rst", card_rst, 1'b0);
        start_n = 1'b1;
        run_down("R5", 1'b1, 1'b1, 1'b1, 1'b1, -1);

        // B: reset request high at start, clock window
        rst_req = 1'b1;
        start_n = 1'b0;
        run_up(0, 14*H + 2, 1'b1, 10*H, 12*H);

        // C: card removal
        pres_n = 1'b1;
        run_down("R7", 1'b1, 1'b1, 1'b1, 1'b0, -1);
        pres_n = 1'b0;
        tick();
        chk("R7", "stat_n", stat_n, 1'b0);
        chk("R10", "pump_en", pump_en, 1'b0);
        start_n = 1'b1; rst_req = 1'b0;
        tick();
        chk("R6", "stat_n", stat_n, 1'b1);

        // D: supply alarm mid power-up
        start_n = 1'b0;
        run_up(0, 5*H, 1'b0, -1, -1);
        supply_alarm = 1'b1;
        run_down("R8", 1'b1, 1'b0, 1'b0, 1'b1, -1);
        tick();
        chk("R10", "pump_en", pump_en, 1'b0);

        // alarm stretch, exact edge of acceptance
        start_n = 1'b1;
        tick();
        supply_alarm = 1'b0;
        start_n = 1'b0;
        for (int k = 1; k <= S; k++) begin
            tick();
            chk("R9", "pump_en", pump_en, 1'b0);
        end
        tick();
        chk("R9", "pump_en", pump_en, 1'b1);
        chk("R9", "vcc_en", vcc_en, 1'b0);
        run_up(1, 14*H + 1, 1'b0, -1, -1);

        // R10: request falling during shutdown is held off
        start_n = 1'b1;
        run_down("R10", 1'b1, 1'b1, 1'b1, 1'b1, 2*H);
        tick();
        chk("R10", "pump_en", pump_en, 1'b1);
        chk("R10", "vcc_en", vcc_en, 1'b0);
        run_up(1, 9*H, 1'b0, -1, -1);

        // E: overcurrent during power-up
        ovc = 1'b1;
        run_down("R7", 1'b1, 1'b1, 1'b1, 1'b0, -1);
        ovc = 1'b0;
        start_n = 1'b1;
        tick();
        chk("R6", "stat_n", stat_n, 1'b1);

        // F: overtemperature with reset released
        start_n = 1'b0;
        run_up(0, 14*H + 2, 1'b0, -1, -1);
        rst_req = 1'b1; tick(); chk("R4", "card_rst", card_rst, 1'b1);
        ovt = 1'b1; tick();
        chk("R7", "card_rst", card_rst, 1'b0);
        chk("R7", "stat_n", stat_n, 1'b0);
        ovt = 1'b0; tick();
        chk("R7", "stat_n", stat_n, 1'b0);
        start_n = 1'b1; rst_req = 1'b0; tick();
        chk("R6", "stat_n", stat_n, 1'b1);
        repeat (10*H + 2) tick();
        chk("R5", "pump_en", pump_en, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule